// File: doc/BRIEF.md
# Configuration Monitor Interrupt Unit

This unit watches a bank of twelve configuration status lines coming from a programmable-logic fabric and condenses them into one interrupt request for a host processor. Each line is first brought into the local clock domain through a two-flop synchronizer. Software then decides, separately for each line, whether that line contributes to the interrupt. It chooses whether the line is level or edge sensitive, which polarity is active, whether the line is enabled, and whether it is masked.

Software sees the synchronized line values, a raw pending register and a pending register gated by enable and mask. It clears pending bits by writing ones to an end-of-interrupt register. A level-type line sets its pending bit again as long as its level stays active. An edge-type line keeps its pending bit until software clears it.

All registers use the same bit layout: line `i` sits at bit `i`. Reads return the line bits zero-extended to the 32-bit bus.

Top module: `cfg_mon_irq`

## Requirements
- R1: While reset is held, the enable, mask, type and polarity registers, the raw pending register, the gated pending register and `irqOut` all read 0.
- R2: Word offsets are 0x00 enable, 0x04 mask, 0x08 type, 0x0C polarity, 0x10 gated pending (read only), 0x14 raw pending (read only), 0x18 end-of-interrupt (write only, reads 0) and 0x1C line state (read only). Reads return bits [11:0] with bits [31:12] zero. Unmapped or unaligned addresses read 0.
- R3: The line state register shows `lineIn` through two flops. A change made before clock edge k is first visible after edge k+1.
- R4: When a line's type bit is 0 (level), its raw pending bit equals the line's active level one edge after synchronization. Polarity bit 1 makes high active; polarity bit 0 makes low active.
- R5: When a line's type bit is 1 (edge), its raw pending bit sets on an active edge and holds until it is cleared. Polarity 1 selects the rising edge and polarity 0 the falling edge; the opposite edge has no effect.
- R6: Writing 1 to an end-of-interrupt bit clears that pending bit at the write edge, and bits written 0 are untouched. A level line whose level is still active shows pending again one edge later.
- R7: Gated pending equals raw pending AND enable AND NOT mask.
- R8: `irqOut` is the OR of the gated pending bits, registered by one clock edge.
- R9: A write changes only the register at its address. Writes to read-only offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 12 | Asynchronous configuration status lines |
| regWe | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 8 | Byte address of the register access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its defaults: twelve lines, a 32-bit bus, an 8-bit address and two synchronizer stages. With these values every line and every upper padding bit can be reached through the register window. A table of level-type configurations pairs line patterns with enable, mask and polarity words, and the bench computes the expected raw, gated and interrupt values from them. Directed tests then cover the following cases:
- synchronizer latency, edge by edge;
- rising and falling edge capture, and holding the bit after the line returns;
- level re-assertion after an end-of-interrupt write;
- the one-edge interrupt delay;
- writes to read-only offsets.

// File: rtl/cfg_mon_irq_pkg.sv
package cfg_mon_irq_pkg;

  // Word indices of the register window (byte offset = index * 4)
  localparam int unsigned WORD_EN     = 0;
  localparam int unsigned WORD_MSK    = 1;
  localparam int unsigned WORD_TYP    = 2;
  localparam int unsigned WORD_POL    = 3;
  localparam int unsigned WORD_GATED  = 4;
  localparam int unsigned WORD_RAW    = 5;
  localparam int unsigned WORD_EOI    = 6;
  localparam int unsigned WORD_LINES  = 7;

  // Write strobes from decode to datapath
  typedef struct packed {
    logic enWe;
    logic mskWe;
    logic typWe;
    logic polWe;
    logic eoiWe;
  } strobe_t;

  // Read source selection
  typedef enum logic [2:0] {
    RD_NONE, RD_EN, RD_MSK, RD_TYP, RD_POL, RD_GATED, RD_RAW, RD_LINES
  } rdsel_e;

endpackage

// File: rtl/cfg_mon_irq_ctrl.sv
module cfg_mon_irq_ctrl
  import cfg_mon_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           stb,
  output rdsel_e            rdSel
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              aligned;

  assign wordIdx = regAddr[ADDR_W-1:2];
  assign aligned = (regAddr[1:0] == 2'b00);

  always_comb begin
    stb   = '0;
    rdSel = RD_NONE;
    if (aligned) begin
      case (wordIdx)
        WORD_W'(WORD_EN):    begin rdSel = RD_EN;    stb.enWe  = regWe; end
        WORD_W'(WORD_MSK):   begin rdSel = RD_MSK;   stb.mskWe = regWe; end
        WORD_W'(WORD_TYP):   begin rdSel = RD_TYP;   stb.typWe = regWe; end
        WORD_W'(WORD_POL):   begin rdSel = RD_POL;   stb.polWe = regWe; end
        WORD_W'(WORD_GATED): rdSel = RD_GATED;
        WORD_W'(WORD_RAW):   rdSel = RD_RAW;
        WORD_W'(WORD_EOI):   stb.eoiWe = regWe;
        WORD_W'(WORD_LINES): rdSel = RD_LINES;
        default:             rdSel = RD_NONE;
      endcase
    end
  end

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb)); // R9
  AST_NO_WRITE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |-> (stb == '0)); // R9

endmodule

// File: rtl/cfg_mon_irq_dp.sv
module cfg_mon_irq_dp
  import cfg_mon_irq_pkg::*;
#(
  parameter int NUM_LINES   = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  strobe_t              stb,
  input  rdsel_e               rdSel,
  input  logic [NUM_LINES-1:0] wBits,
  output logic [DATA_W-1:0]    rdata,
  output logic                 irqOut
);

  localparam int PAD_W = DATA_W - NUM_LINES;

  logic [NUM_LINES-1:0] enReg, mskReg, typReg, polReg;
  logic [NUM_LINES-1:0] syncQ [SYNC_STAGES];
  logic [NUM_LINES-1:0] lineSync, prevQ;
  logic [NUM_LINES-1:0] actLvl, edgeEv, clrBit, pend, gated;

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg  <= '0;
      mskReg <= '0;
      typReg <= '0;
      polReg <= '0;
    end else begin
      if (stb.enWe)  enReg  <= wBits;
      if (stb.mskWe) mskReg <= wBits;
      if (stb.typWe) typReg <= wBits;
      if (stb.polWe) polReg <= wBits;
    end
  end

  // Synchronizer chain and edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < SYNC_STAGES; k++) syncQ[k] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= lineIn;
      for (int k = 1; k < SYNC_STAGES; k++) syncQ[k] <= syncQ[k-1];
      prevQ <= lineSync;
    end
  end

  assign lineSync = syncQ[SYNC_STAGES-1];

  // Per-line detection and pending latch
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign actLvl[g] = polReg[g] ? lineSync[g] : ~lineSync[g];
    assign edgeEv[g] = polReg[g] ? (lineSync[g] & ~prevQ[g])
                                 : (~lineSync[g] & prevQ[g]);
    assign clrBit[g] = stb.eoiWe & wBits[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          pend[g] <= 1'b0;
      else if (typReg[g]) pend[g] <= edgeEv[g] | (pend[g] & ~clrBit[g]);
      else                pend[g] <= actLvl[g] & ~clrBit[g];
    end
  end

  assign gated = pend & enReg & ~mskReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |gated;
  end

  // Read mux
  logic [NUM_LINES-1:0] rdBits;
  always_comb begin
    case (rdSel)
      RD_EN:    rdBits = enReg;
      RD_MSK:   rdBits = mskReg;
      RD_TYP:   rdBits = typReg;
      RD_POL:   rdBits = polReg;
      RD_GATED: rdBits = gated;
      RD_RAW:   rdBits = pend;
      RD_LINES: rdBits = lineSync;
      default:  rdBits = '0;
    endcase
  end
  assign rdata = {{PAD_W{1'b0}}, rdBits};

  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stb.eoiWe |=> ((pend & $past(wBits) & ~$past(typReg & edgeEv)) == '0)); // R6
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.typWe |=> ((pend & $past(pend & typReg & ~clrBit))
                    == $past(pend & typReg & ~clrBit))); // R5
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (gated != '0) |=> irqOut); // R8
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (gated == '0) |=> !irqOut); // R8
  AST_GATED_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ($past(pend & enReg & ~mskReg) != '0)); // R7

endmodule

// File: rtl/cfg_mon_irq.sv
module cfg_mon_irq
  import cfg_mon_irq_pkg::*;
#(
  parameter int NUM_LINES   = 12,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic                 regWe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 irqOut
);

  strobe_t stb;
  rdsel_e  rdSel;
  wire     unusedWdataHi = ^regWdata[DATA_W-1:NUM_LINES];

  cfg_mon_irq_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWe   (regWe),
    .regAddr (regAddr),
    .stb     (stb),
    .rdSel   (rdSel)
  );

  cfg_mon_irq_dp #(
    .NUM_LINES   (NUM_LINES),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .lineIn (lineIn),
    .stb    (stb),
    .rdSel  (rdSel),
    .wBits  (regWdata[NUM_LINES-1:0]),
    .rdata  (regRdata),
    .irqOut (irqOut)
  );

endmodule

// File: tb/cfg_mon_irq_bench.sv
`timescale 1ns/1ps
module cfg_mon_irq_bench;

  localparam logic [7:0] A_EN = 8'h00, A_MSK = 8'h04, A_TYP = 8'h08, A_POL = 8'h0C;
  localparam logic [7:0] A_GATED = 8'h10, A_RAW = 8'h14, A_EOI = 8'h18, A_LINES = 8'h1C;

  // {lines, enable, mask, polarity}, all lines level type
  localparam int NV = 8;
  localparam logic [47:0] VECS [NV] = '{
    48'h000_FFF_000_FFF, 48'hFFF_FFF_000_FFF, 48'hA5A_FFF_0F0_FFF,
    48'hA5A_00F_000_000, 48'h800_800_800_FFF, 48'h001_001_000_000,
    48'h3C3_F0F_00F_0F0, 48'h000_000_000_000 };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] lineIn = '0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut;
  int          nChk = 0, nFail = 0;

  always #2.5 clk = ~clk;

  cfg_mon_irq u_cfg_mon_irq (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    regAddr = a;
    #0.5;
    v = regRdata;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    logic [11:0] ln, en, mk, pl, rawE, gatE;

    // R1: values while reset is held
    waitN(3);
    rd(A_EN, v);    chk("R1 enable", v, 0);
    rd(A_MSK, v);   chk("R1 mask", v, 0);
    rd(A_TYP, v);   chk("R1 type", v, 0);
    rd(A_POL, v);   chk("R1 polarity", v, 0);
    rd(A_RAW, v);   chk("R1 raw", v, 0);
    rd(A_GATED, v); chk("R1 gated", v, 0);
    chk("R1 irq", {31'b0, irqOut}, 0);
    @(negedge clk); rstN = 1'b1;
    waitN(2);

    // Table walk: R4 level polarity, R7 gating, R8 interrupt
    for (int i = 0; i < NV; i++) begin
      {ln, en, mk, pl} = VECS[i];
      wr(A_EN, {20'b0, en});
      wr(A_MSK, {20'b0, mk});
      wr(A_POL, {20'b0, pl});
      lineIn = ln;
      waitN(5);
      rawE = ~(ln ^ pl);
      gatE = rawE & en & ~mk;
      rd(A_RAW, v);   chk($sformatf("R4 vec%0d raw", i), v, {20'b0, rawE});
      rd(A_GATED, v); chk($sformatf("R7 vec%0d gated", i), v, {20'b0, gatE});
      chk($sformatf("R8 vec%0d irq", i), {31'b0, irqOut}, {31'b0, |gatE});
      rd(A_LINES, v); chk($sformatf("R3 vec%0d lines", i), v, {20'b0, ln});
    end

    // R2: width, unmapped, unaligned, eoi reads 0
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, v);   chk("R2 enable upper bits zero", v, 32'h0000_0FFF);
    wr(A_TYP, 32'h0000_0000);
    rd(8'h40, v);  chk("R2 unmapped read", v, 0);
    rd(8'h05, v);  chk("R2 unaligned read", v, 0);
    rd(A_EOI, v);  chk("R2 eoi reads zero", v, 0);

    // R9: writes affect only the addressed register
    wr(A_MSK, 32'h0000_0123);
    wr(A_EN, 32'h0000_0456);
    rd(A_MSK, v);  chk("R9 mask kept after enable write", v, 32'h123);
    lineIn = 12'h0F0; wr(A_POL, 32'hFFF);
    waitN(4);
    rd(A_RAW, v);
    wr(A_RAW, 32'h0000_0000);
    wr(A_GATED, 32'h0000_0FFF);
    wr(A_LINES, 32'h0000_0000);
    rd(A_RAW, v2); chk("R9 raw unchanged by read-only writes", v2, v);
    chk("R9 raw value", v2, 32'h0F0);

    // R3: synchronizer latency
    lineIn = 12'h00F;            // before edge k
    @(negedge clk); rd(A_LINES, v); chk("R3 after one edge old", v, 32'h0F0);
    @(negedge clk); rd(A_LINES, v); chk("R3 after two edges new", v, 32'h00F);

    // R5: edge type on bit 0, rising
    wr(A_MSK, 0); wr(A_EN, 32'h001);
    lineIn = 12'h000;
    wr(A_POL, 32'h001); wr(A_TYP, 32'h001);
    waitN(4);
    wr(A_EOI, 32'h001);
    waitN(2);
    rd(A_RAW, v); chk("R5 edge idle", v & 1, 0);
    lineIn = 12'h001; waitN(4);
    rd(A_RAW, v); chk("R5 rising captured", v & 1, 1);
    chk("R8 edge irq", {31'b0, irqOut}, 1);
    lineIn = 12'h000; waitN(4);
    rd(A_RAW, v); chk("R5 held after line falls", v & 1, 1);
    wr(A_EOI, 32'h001);
    rd(A_RAW, v); chk("R6 edge eoi clears", v & 1, 0);
    waitN(3);
    rd(A_RAW, v); chk("R5 stays clear", v & 1, 0);
    chk("R8 irq dropped", {31'b0, irqOut}, 0);
    // falling edge with polarity 0
    wr(A_POL, 32'h000);
    lineIn = 12'h001; waitN(4);
    rd(A_RAW, v); chk("R5 rising ignored at pol0", v & 1, 0);
    lineIn = 12'h000; waitN(4);
    rd(A_RAW, v); chk("R5 falling captured at pol0", v & 1, 1);

    // R6: level reassert and zero bits untouched
    wr(A_TYP, 0); wr(A_POL, 32'hFFF); wr(A_EN, 0);
    lineIn = 12'h004; waitN(4);
    rd(A_RAW, v); chk("R4 level high active", v, 32'h004);
    wr(A_EOI, 32'h000);
    rd(A_RAW, v); chk("R6 eoi zero bits no effect", v, 32'h004);
    wr(A_EOI, 32'h004);
    rd(A_RAW, v); chk("R6 level cleared at write edge", v, 0);
    @(negedge clk);
    rd(A_RAW, v); chk("R6 level reasserts", v, 32'h004);

    // R8: one-edge delay from gated to irq
    chk("R8 irq low while disabled", {31'b0, irqOut}, 0);
    wr(A_EN, 32'h004);
    rd(A_GATED, v); chk("R7 gated right after enable", v, 32'h004);
    chk("R8 irq not yet", {31'b0, irqOut}, 0);
    @(negedge clk);
    chk("R8 irq one edge later", {31'b0, irqOut}, 1);
    wr(A_MSK, 32'h004);
    chk("R8 irq still high at mask edge", {31'b0, irqOut}, 1);
    @(negedge clk);
    chk("R8 irq low after mask", {31'b0, irqOut}, 0);

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule